// File: doc/BRIEF.md
# Single-Bit Boolean Processor

This unit executes single-bit instructions against a flat space of 256 directly addressable bits. The carry flag serves as a one-bit accumulator. A caller hands over an absolute 8-bit bit address, a 4-bit operation code and the present carry value. The unit finds the byte that holds the bit and reads that byte through a byte-wide memory port. It then computes the result. Where the operation changes the bit, it writes the byte back one cycle after the read, with only that one bit altered. Every operation returns its new carry value and a branch decision. The caller uses these to update its flag and its program counter.

Bit addresses 0x00 to 0x7F map onto sixteen general RAM bytes starting at 0x20. Bit addresses 0x80 to 0xFF map onto the sixteen special-register bytes whose addresses are multiples of eight. The carry itself is bit 7 of the status byte at 0xD0, which is bit address 0xD7. The unit treats that one address as the live carry. The test-and-clear jump runs as one uninterrupted read-modify-write. It writes only when it finds the bit set.

Top module: `bitproc_unit`

## Requirements
- R1: After reset `op_ready` is 1, and `mem_rd_en`, `mem_wr_en`, `done` and `jump_taken` are 0. Outside an operation no memory strobe is issued.
- R2: An operation is accepted on a clock edge where `op_valid` and `op_ready` are both 1. In the next cycle `mem_rd_en` is 1. In the cycle after that `done` is 1, and the read data is expected in that cycle. `op_ready` is 0 in both of these cycles and is 1 again in the cycle after `done`.
- R3: A bit address below 0x80 selects byte 0x20 + addr[6:3] on `mem_addr`. The bit within the byte is addr[2:0].
- R4: A bit address of 0x80 or above selects byte {addr[7:3], 3'b000} on `mem_addr`. The bit within the byte is addr[2:0].
- R5: Op 0 sets the bit, op 1 clears it and op 2 inverts it. Each one asserts `mem_wr_en` in the `done` cycle, at the same `mem_addr` as the read. In `mem_wdata` every other bit equals the byte that was read.
- R6: Op 3 copies the bit into `carry_out` and writes nothing. Op 4 writes `carry_in` into the bit.
- R7: Ops 5, 6, 7 and 8 give `carry_out` as, in order, carry AND bit, carry AND NOT bit, carry OR bit, and carry OR NOT bit. They write nothing.
- R8: Op 9 raises `jump_taken` when the bit is 1. Op 10 raises it when the bit is 0. Neither op writes.
- R9: Op 11 raises `jump_taken` and writes the byte back with the bit cleared when the bit is 1. When the bit is 0 it issues no write strobe.
- R10: Op codes 12 to 15 write nothing, leave `jump_taken` at 0 and return `carry_out` equal to `carry_in`. Any op that does not name the carry as a result returns `carry_out` equal to `carry_in`. Any op other than 9, 10 and 11 leaves `jump_taken` at 0.
- R11: At bit address 0xD7, reads of the bit use `carry_in` rather than the memory byte. A write to the bit also sets `carry_out` to the bit value written. Bits 0 to 6 of that byte are still preserved.
- R12: `carry_out` and `jump_taken` are meaningful only while `done` is 1 and are 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation request |
| op_ready | output | 1 | Unit can accept an operation |
| op_code | input | 4 | Bit operation code |
| bit_addr | input | 8 | Absolute bit address |
| carry_in | input | 1 | Current carry flag |
| mem_addr | output | 8 | Byte address to memory |
| mem_rd_en | output | 1 | Byte read strobe; data returned next cycle |
| mem_rdata | input | 8 | Byte read data |
| mem_wr_en | output | 1 | Byte write strobe |
| mem_wdata | output | 8 | Byte write data |
| done | output | 1 | Result cycle of an operation |
| carry_out | output | 1 | New carry flag, valid with done |
| jump_taken | output | 1 | Branch decision, valid with done |

## Verification
The hardest case to reach is a write that lands on the carry-alias bit 0xD7. In that case the byte value, the preserved low seven bits of the status byte and the returned carry must all agree. Random stimulus seldom lands on that one address with the right carry. The stimulus therefore runs every op code at 0xD7 with both carry values. It also runs the test-and-clear jump on bits it first forces to each state. The bench mirrors every byte, so a stray write to any other bit is caught.

// File: rtl/bitproc_pkg.sv
package bitproc_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    BOP_SET   = 4'd0,
    BOP_CLR   = 4'd1,
    BOP_INV   = 4'd2,
    BOP_TOC   = 4'd3,
    BOP_FROMC = 4'd4,
    BOP_AND   = 4'd5,
    BOP_ANDN  = 4'd6,
    BOP_OR    = 4'd7,
    BOP_ORN   = 4'd8,
    BOP_JSET  = 4'd9,
    BOP_JCLR  = 4'd10,
    BOP_JSCLR = 4'd11
  } bop_e;

  typedef struct packed {
    logic bit_new;
    logic wr;
    logic carry_new;
    logic jump;
  } bop_res_t;

  // Result of one bit operation on bit value b with carry c.
  function automatic bop_res_t bop_eval(input logic [OP_W-1:0] op, input logic b, input logic c);
    bop_res_t r;
    r.bit_new   = b;
    r.wr        = 1'b0;
    r.carry_new = c;
    r.jump      = 1'b0;
    case (op)
      BOP_SET:   begin r.bit_new = 1'b1; r.wr = 1'b1; end
      BOP_CLR:   begin r.bit_new = 1'b0; r.wr = 1'b1; end
      BOP_INV:   begin r.bit_new = ~b;   r.wr = 1'b1; end
      BOP_TOC:   r.carry_new = b;
      BOP_FROMC: begin r.bit_new = c; r.wr = 1'b1; end
      BOP_AND:   r.carry_new = c & b;
      BOP_ANDN:  r.carry_new = c & ~b;
      BOP_OR:    r.carry_new = c | b;
      BOP_ORN:   r.carry_new = c | ~b;
      BOP_JSET:  r.jump = b;
      BOP_JCLR:  r.jump = ~b;
      BOP_JSCLR: begin r.jump = b; r.wr = b; r.bit_new = 1'b0; end
      default:   ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/bitproc_addr_map.sv
module bitproc_addr_map #(
  parameter int              ADDR_W   = 8,
  parameter int              IDX_W    = 3,
  parameter logic [ADDR_W-1:0] RAM_BASE = 8'h20
) (
  input  logic [ADDR_W-1:0] bit_addr,
  output logic [ADDR_W-1:0] byte_addr,
  output logic [IDX_W-1:0]  bit_idx
);
  logic upper_half;
  assign upper_half = bit_addr[ADDR_W-1];
  assign bit_idx    = bit_addr[IDX_W-1:0];
  assign byte_addr  = upper_half ? {bit_addr[ADDR_W-1:IDX_W], {IDX_W{1'b0}}}
                                 : RAM_BASE + ADDR_W'(bit_addr[ADDR_W-2:IDX_W]);
endmodule

// File: rtl/bitproc_alu.sv
module bitproc_alu
  import bitproc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] rdata,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic              carry,
  input  logic              cy_hit,
  output logic [DATA_W-1:0] wdata,
  output logic              wr,
  output logic              carry_new,
  output logic              jump
);
  logic     bit_cur;
  bop_res_t res;

  always_comb begin
    bit_cur   = cy_hit ? carry : rdata[bit_idx];
    res       = bop_eval(op, bit_cur, carry);
    wr        = res.wr;
    jump      = res.jump;
    carry_new = (cy_hit && res.wr) ? res.bit_new : res.carry_new;
  end

  for (genvar g = 0; g < DATA_W; g++) begin : g_merge
    assign wdata[g] = (bit_idx == IDX_W'(g)) ? res.bit_new : rdata[g];
  end
endmodule

// File: rtl/bitproc_seq.sv
module bitproc_seq #(
  parameter int ADDR_W = 8,
  parameter int OP_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [OP_W-1:0]   op_code,
  input  logic [ADDR_W-1:0] bit_addr,
  input  logic              carry_in,
  output logic              ready,
  output logic              rd_phase,
  output logic              ex_phase,
  output logic [OP_W-1:0]   lat_op,
  output logic [ADDR_W-1:0] lat_addr,
  output logic              lat_carry
);
  typedef enum logic [1:0] {S_IDLE, S_READ, S_EXEC} st_e;
  st_e st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      lat_op    <= '0;
      lat_addr  <= '0;
      lat_carry <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (op_valid) begin
          st        <= S_READ;
          lat_op    <= op_code;
          lat_addr  <= bit_addr;
          lat_carry <= carry_in;
        end
        S_READ:  st <= S_EXEC;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ready    = (st == S_IDLE);
  assign rd_phase = (st == S_READ);
  assign ex_phase = (st == S_EXEC);
endmodule

// File: rtl/bitproc_unit.sv
module bitproc_unit
  import bitproc_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] RAM_BASE = 8'h20,
  parameter logic [ADDR_W-1:0] CY_ADDR  = 8'hD7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [OP_W-1:0]   op_code,
  input  logic [ADDR_W-1:0] bit_addr,
  input  logic              carry_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_en,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_wr_en,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              done,
  output logic              carry_out,
  output logic              jump_taken
);
  localparam int IDX_W = $clog2(DATA_W);

  // named internal events
  logic              evt_rd;
  logic              evt_ex;
  logic [OP_W-1:0]   lat_op;
  logic [ADDR_W-1:0] lat_addr;
  logic              lat_carry;
  logic [IDX_W-1:0]  sel_idx;
  logic              cy_hit;
  logic              alu_wr;
  logic              alu_carry;
  logic              alu_jump;

  bitproc_seq #(.ADDR_W(ADDR_W), .OP_W(OP_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .bit_addr(bit_addr), .carry_in(carry_in), .ready(op_ready),
    .rd_phase(evt_rd), .ex_phase(evt_ex), .lat_op(lat_op),
    .lat_addr(lat_addr), .lat_carry(lat_carry)
  );

  bitproc_addr_map #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .RAM_BASE(RAM_BASE)) u_map (
    .bit_addr(lat_addr), .byte_addr(mem_addr), .bit_idx(sel_idx)
  );

  assign cy_hit = (lat_addr == CY_ADDR);

  bitproc_alu #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_alu (
    .op(lat_op), .rdata(mem_rdata), .bit_idx(sel_idx), .carry(lat_carry),
    .cy_hit(cy_hit), .wdata(mem_wdata), .wr(alu_wr),
    .carry_new(alu_carry), .jump(alu_jump)
  );

  assign mem_rd_en  = evt_rd;
  assign done       = evt_ex;
  assign mem_wr_en  = evt_ex & alu_wr;
  assign carry_out  = evt_ex & alu_carry;
  assign jump_taken = evt_ex & alu_jump;
endmodule

// File: rtl/bitproc_unit_chk.sv
module bitproc_unit_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              op_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd_en,
  input logic [DATA_W-1:0] mem_rdata,
  input logic              mem_wr_en,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              done,
  input logic              jump_taken
);
  // R1
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd_en, mem_wr_en}));

  // R2
  rd_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready) |=> mem_rd_en);

  // R2
  done_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> done);

  // R2
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en || done) |-> !op_ready);

  // R5
  wr_same_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (done && $stable(mem_addr)));

  // R5
  one_bit_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> ($countones(mem_wdata ^ mem_rdata) <= 1));

  // R12
  jump_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jump_taken |-> done);
endmodule

bind bitproc_unit bitproc_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
  .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata),
  .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata), .done(done),
  .jump_taken(jump_taken)
);

// File: tb/bitproc_unit_bench.sv
module bitproc_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic       op_ready;
  logic [3:0] op_code = '0;
  logic [7:0] bit_addr = '0;
  logic       carry_in = 1'b0;
  logic [7:0] mem_addr;
  logic       mem_rd_en;
  logic [7:0] mem_rdata;
  logic       mem_wr_en;
  logic [7:0] mem_wdata;
  logic       done;
  logic       carry_out;
  logic       jump_taken;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  logic [7:0] bmem [0:255];
  logic [7:0] ref_mem [0:255];

  always #10 clk = ~clk;

  bitproc_unit u_bitproc_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .bit_addr(bit_addr), .carry_in(carry_in),
    .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata),
    .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata), .done(done),
    .carry_out(carry_out), .jump_taken(jump_taken)
  );

  // memory model: registered read, write at edge
  always @(posedge clk) begin
    if (mem_wr_en) bmem[mem_addr] <= mem_wdata;
    if (mem_rd_en) mem_rdata <= bmem[mem_addr];
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // reference: byte holding a bit address
  function automatic int ref_byte(input int a);
    if (a < 128) return 32 + a / 8;
    return a - (a % 8);
  endfunction

  task automatic run_op(input int op, input int a, input bit c);
    int  byt, pos;
    bit  b, nb, nc, jmp, wr;
    logic [7:0] old, nxt;
    byt = ref_byte(a);
    pos = a % 8;
    old = ref_mem[byt];
    b   = (a == 215) ? c : old[pos];
    nb = b; nc = c; jmp = 0; wr = 0;
    if (op == 0) begin nb = 1; wr = 1; end
    else if (op == 1) begin nb = 0; wr = 1; end
    else if (op == 2) begin nb = !b; wr = 1; end
    else if (op == 3) nc = b;
    else if (op == 4) begin nb = c; wr = 1; end
    else if (op == 5) nc = c && b;
    else if (op == 6) nc = c && !b;
    else if (op == 7) nc = c || b;
    else if (op == 8) nc = c || !b;
    else if (op == 9) jmp = b;
    else if (op == 10) jmp = !b;
    else if (op == 11) begin jmp = b; if (b) begin wr = 1; nb = 0; end end
    if (wr && a == 215) nc = nb;
    nxt = old;
    nxt[pos] = nb;

    @(negedge clk);
    chk(op_ready === 1'b1, "R2 ready idle", op_ready, 1);
    op_valid = 1; op_code = 4'(op); bit_addr = 8'(a); carry_in = c;
    @(negedge clk);
    op_valid = 0;
    chk(mem_rd_en === 1'b1 && op_ready === 1'b0 && done === 1'b0, "R2 read cycle",
        {mem_rd_en, op_ready, done}, 3'b100);
    chk(mem_addr === 8'(byt), a < 128 ? "R3 ram byte" : "R4 sfr byte", mem_addr, byt);
    @(negedge clk);
    chk(done === 1'b1 && op_ready === 1'b0, "R2 done cycle", {done, op_ready}, 2'b10);
    chk(mem_wr_en === wr, op == 11 ? "R9 jsclr strobe" : "R5 write strobe", mem_wr_en, wr);
    if (wr) chk(mem_wdata === nxt, a == 215 ? "R11 alias byte" : "R5 wdata", mem_wdata, nxt);
    chk(carry_out === nc, a == 215 ? "R11 carry" : (op >= 12 ? "R10 carry" : "R7 carry"), carry_out, nc);
    chk(jump_taken === jmp, op >= 9 && op <= 10 ? "R8 jump" : "R10 jump", jump_taken, jmp);
    if (wr) ref_mem[byt] = nxt;
    @(negedge clk);
    chk(op_ready === 1'b1 && done === 1'b0 && carry_out === 1'b0 && jump_taken === 1'b0,
        "R12 idle outputs", {op_ready, done, carry_out, jump_taken}, 4'b1000);
  endtask

  task automatic cmp_mem();
    int diffs = 0;
    for (int i = 0; i < 256; i++) if (bmem[i] !== ref_mem[i]) diffs++;
    chk(diffs == 0, "R5 untouched bits", diffs, 0);
  endtask

  initial begin
    int lf;
    for (int i = 0; i < 256; i++) begin
      bmem[i] = 8'((i * 37) ^ 8'h5A);
      ref_mem[i] = bmem[i];
    end
    mem_rdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(op_ready === 1'b1 && mem_rd_en === 1'b0 && mem_wr_en === 1'b0 && done === 1'b0,
        "R1 reset state", {op_ready, mem_rd_en, mem_wr_en, done}, 4'b1000);
    rst_n = 1;
    @(negedge clk);
    chk(mem_rd_en === 1'b0 && mem_wr_en === 1'b0 && jump_taken === 1'b0,
        "R1 idle after reset", {mem_rd_en, mem_wr_en, jump_taken}, 0);

    // R3 R4 boundaries with every op
    for (int op = 0; op < 16; op++) begin
      run_op(op, 8'h00, 1'b1);
      run_op(op, 8'h7F, 1'b0);
      run_op(op, 8'h80, 1'b1);
      run_op(op, 8'hFF, 1'b0);
    end
    // R6 move both ways
    run_op(4, 8'h13, 1'b1); run_op(3, 8'h13, 1'b0);
    run_op(4, 8'h13, 1'b0); run_op(3, 8'h13, 1'b1);
    // R9 test-and-clear on set and on clear bit
    run_op(0, 8'h2A, 1'b0); run_op(11, 8'h2A, 1'b0); run_op(11, 8'h2A, 1'b0);
    run_op(9, 8'h2A, 1'b0); run_op(10, 8'h2A, 1'b0);
    cmp_mem();
    // R11 carry alias, every op with both carries
    for (int op = 0; op < 16; op++) begin
      run_op(op, 8'hD7, 1'b0);
      run_op(op, 8'hD7, 1'b1);
    end
    cmp_mem();
    // mixed stimulus
    lf = 16'hACE1;
    for (int k = 0; k < 600; k++) begin
      lf = ((lf >> 1) ^ ((lf & 1) ? 16'hB400 : 0)) & 16'hFFFF;
      run_op(lf % 16, (lf >> 4) & 8'hFF, (lf >> 12) & 1);
      if (k % 50 == 0) cmp_mem();
    end
    cmp_mem();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule